// File: doc/BRIEF.md
# TLB Maintenance Instruction Permission Checker

This block sits in the decode stage of a processor core. It looks at one system-instruction encoding and decides what happens to it. It recognises two forms of an address-space-identifier TLB invalidation, both broadcast to the outer-shareable domain. The base form invalidates entries of every attribute. The second form leaves out entries that carry the extended-sync attribute. The block does not perform the invalidation. It only chooses the outcome.

Each request brings the five encoding fields, the current exception level, the implemented-feature flags, and the hypervisor and secure-monitor control bits. The block resolves a fixed priority among the possible outcomes:

- feature gating,
- exception-level checks,
- a coarse hypervisor trap,
- a fine-grained hypervisor trap, with a qualifier for the extended-sync form,
- a secure-monitor security-state check.

A recognised encoding gives exactly one outcome: undefined, trap to EL2, ignored, or executed. An encoding that matches neither form raises only a no-match flag. The result is registered and appears one cycle after the request strobe, together with a trap syndrome class and the variant flag.

Top module: `tlbm_perm_top`

## Requirements
- R1: The base form is op0=2'b01, op1=3'b000, CRn=4'b1000, CRm=4'b0001, op2=3'b010. When any field differs from both forms, res_nomatch is high and undef, trap, ignore and execute are all low.
- R2: The extended-sync form uses the same fields except CRn=4'b1001. It gives undefined when feat_xs is low, even at EL2 or EL3.
- R3: Either form gives undefined when feat_os_inval or feat_a64 is low. This check takes priority over every other outcome.
- R4: At EL0 (cur_el=2'd0), a recognised form gives undefined.
- R5: At EL1 (cur_el=2'd1) with ctl_el2_en high, a recognised form traps when ctl_trap_tlb or ctl_trap_os is set. On a trap, res_ec is 6'h18; otherwise res_ec is 0.
- R6: At EL1 with ctl_el2_en high and neither coarse bit set, a recognised form traps when all of these hold: feat_fgt is high, either feat_el3 is low or ctl_el3_fgt_en is high, and ctl_fgt_inst is high.
- R7: For the extended-sync form, the fine-grained trap of R6 also needs feat_hcx high and either ctl_hcx_en low or ctl_hcx_fgt_nxs low. When this condition fails, the instruction executes.
- R8: At EL2 (cur_el=2'd2), a recognised form that passes R2 and R3 always executes, whatever the trap bits say.
- R9: At EL3 (cur_el=2'd3), a recognised form gives ignored when feat_realm is high and ctl_el1_sec_ok is low. Otherwise it executes.
- R10: res_vld is high exactly one cycle after req_vld. When res_vld is high, exactly one of nomatch, undef, trap, ignore and execute is high. Without a strobe, all result outputs hold their values.
- R11: res_excl_xs is high only when the result is execute and the request was the extended-sync form.
- R12: At EL1 with ctl_el2_en low, a recognised form that passes R2 and R3 executes, whatever the trap bits say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe |
| enc_op0 | input | 2 | Encoding field op0 |
| enc_op1 | input | 3 | Encoding field op1 |
| enc_crn | input | 4 | Encoding field CRn |
| enc_crm | input | 4 | Encoding field CRm |
| enc_op2 | input | 3 | Encoding field op2 |
| cur_el | input | 2 | Current exception level |
| feat_os_inval | input | 1 | Outer-shareable TLB invalidation implemented |
| feat_a64 | input | 1 | 64-bit execution state implemented |
| feat_xs | input | 1 | Extended-sync attribute implemented |
| feat_fgt | input | 1 | Fine-grained traps implemented |
| feat_el3 | input | 1 | EL3 implemented |
| feat_hcx | input | 1 | Extended hypervisor control implemented |
| feat_realm | input | 1 | Realm management implemented |
| ctl_el2_en | input | 1 | EL2 enabled for the current state |
| ctl_trap_tlb | input | 1 | Hypervisor coarse trap of all TLB maintenance |
| ctl_trap_os | input | 1 | Hypervisor coarse trap of outer-shareable TLB maintenance |
| ctl_el3_fgt_en | input | 1 | Secure-monitor enable of fine-grained traps |
| ctl_fgt_inst | input | 1 | Fine-grained trap bit for this instruction |
| ctl_hcx_en | input | 1 | Extended hypervisor control register enabled |
| ctl_hcx_fgt_nxs | input | 1 | Exempts the extended-sync form from fine-grained trap |
| ctl_el1_sec_ok | input | 1 | EL1 has a valid security state |
| res_vld | output | 1 | Result valid |
| res_nomatch | output | 1 | Encoding matched neither form |
| res_undef | output | 1 | Undefined |
| res_trap | output | 1 | Trap to EL2 |
| res_ignore | output | 1 | Silently ignored |
| res_exec | output | 1 | Executed |
| res_excl_xs | output | 1 | Executed form excludes extended-sync entries |
| res_ec | output | 6 | Trap syndrome class |

## Verification
The bench builds the block with its default parameters. These keep the extended-sync form decodable and set the trap class to 0x18, so both forms and every outcome can be reached. A pseudo-random sweep covers all four exception levels, both forms and single-field encoding mismatches, with every feature and control bit varied. This reaches the deep trap qualifiers of R6 and R7 alongside the higher-priority gates. Directed cases pin the priority edges, and one case checks that outputs hold while no strobe is given.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

  typedef enum logic [2:0] {
    VERD_NOMATCH = 3'd0,
    VERD_UNDEF   = 3'd1,
    VERD_TRAP    = 3'd2,
    VERD_IGNORE  = 3'd3,
    VERD_EXEC    = 3'd4
  } verdict_e;

  typedef struct packed {
    logic os_inval;
    logic a64;
    logic xs;
    logic fgt;
    logic el3;
    logic hcx;
    logic realm;
  } feat_t;

  typedef struct packed {
    logic el2_en;
    logic trap_tlb;
    logic trap_os;
    logic el3_fgt_en;
    logic fgt_inst;
    logic hcx_en;
    logic hcx_fgt_nxs;
    logic el1_sec_ok;
  } ctl_t;

  localparam logic [1:0] EL_0 = 2'd0;
  localparam logic [1:0] EL_1 = 2'd1;
  localparam logic [1:0] EL_2 = 2'd2;
  localparam logic [1:0] EL_3 = 2'd3;

endpackage

// File: rtl/tlbm_decode.sv
module tlbm_decode #(
  parameter int OP0_W = 2,
  parameter int OP1_W = 3,
  parameter int CRN_W = 4,
  parameter int CRM_W = 4,
  parameter int OP2_W = 3,
  parameter logic [OP0_W-1:0] ENC_OP0  = 2'b01,
  parameter logic [OP1_W-1:0] ENC_OP1  = 3'b000,
  parameter logic [CRN_W-1:0] ENC_CRN  = 4'b1000,
  parameter logic [CRN_W-1:0] ENC_CRNX = 4'b1001,
  parameter logic [CRM_W-1:0] ENC_CRM  = 4'b0001,
  parameter logic [OP2_W-1:0] ENC_OP2  = 3'b010,
  parameter bit XS_FORM_EN = 1'b1
) (
  input  logic [OP0_W-1:0] op0,
  input  logic [OP1_W-1:0] op1,
  input  logic [CRN_W-1:0] crn,
  input  logic [CRM_W-1:0] crm,
  input  logic [OP2_W-1:0] op2,
  output logic             hit_base,
  output logic             hit_nxs
);

  logic shared_ok;

  always_comb begin
    shared_ok = (op0 == ENC_OP0) && (op1 == ENC_OP1) &&
                (crm == ENC_CRM) && (op2 == ENC_OP2);
    hit_base  = shared_ok && (crn == ENC_CRN);
  end

  generate
    if (XS_FORM_EN) begin : g_xs_form
      always_comb hit_nxs = shared_ok && (crn == ENC_CRNX);
    end else begin : g_no_xs_form
      always_comb hit_nxs = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/tlbm_perm.sv
module tlbm_perm
  import tlbm_pkg::*;
(
  input  logic     hit_base,
  input  logic     hit_nxs,
  input  logic [1:0] el,
  input  feat_t    feat,
  input  ctl_t     ctl,
  output verdict_e verdict,
  output logic     excl_xs
);

  logic coarse_hit;
  logic fgt_gate;
  logic nxs_qual;
  logic fgt_hit;
  logic feat_ok;

  always_comb begin
    feat_ok    = feat.os_inval && feat.a64 && (!hit_nxs || feat.xs);
    coarse_hit = ctl.el2_en && (ctl.trap_tlb || ctl.trap_os);
    fgt_gate   = ctl.el2_en && feat.fgt && (!feat.el3 || ctl.el3_fgt_en) && ctl.fgt_inst;
    nxs_qual   = !hit_nxs || (feat.hcx && (!ctl.hcx_en || !ctl.hcx_fgt_nxs));
    fgt_hit    = fgt_gate && nxs_qual;
  end

  always_comb begin
    verdict = VERD_NOMATCH;
    if (hit_base || hit_nxs) begin
      if (!feat_ok) begin
        verdict = VERD_UNDEF;
      end else begin
        unique case (el)
          EL_0: verdict = VERD_UNDEF;
          EL_1: verdict = (coarse_hit || fgt_hit) ? VERD_TRAP : VERD_EXEC;
          EL_2: verdict = VERD_EXEC;
          EL_3: verdict = (feat.realm && !ctl.el1_sec_ok) ? VERD_IGNORE : VERD_EXEC;
          default: verdict = VERD_UNDEF;
        endcase
      end
    end
    excl_xs = (verdict == VERD_EXEC) && hit_nxs;
  end

endmodule

// File: rtl/tlbm_resreg.sv
module tlbm_resreg
  import tlbm_pkg::*;
#(
  parameter int EC_W = 6,
  parameter logic [EC_W-1:0] TRAP_EC = 6'h18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_vld,
  input  verdict_e        verdict,
  input  logic            excl_xs,
  output logic            res_vld,
  output logic            res_nomatch,
  output logic            res_undef,
  output logic            res_trap,
  output logic            res_ignore,
  output logic            res_exec,
  output logic            res_excl_xs,
  output logic [EC_W-1:0] res_ec
);

  localparam int FLAG_W = 6;

  logic [FLAG_W-1:0] flags_d, flags_q;
  logic [EC_W-1:0]   ec_d, ec_q;
  logic              vld_d, vld_q;

  always_comb begin
    vld_d   = req_vld;
    flags_d = flags_q;
    ec_d    = ec_q;
    if (req_vld) begin
      flags_d = {verdict == VERD_NOMATCH, verdict == VERD_UNDEF, verdict == VERD_TRAP,
                 verdict == VERD_IGNORE, verdict == VERD_EXEC, excl_xs};
      ec_d    = (verdict == VERD_TRAP) ? TRAP_EC : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      flags_q <= '0;
      ec_q    <= '0;
    end else begin
      vld_q   <= vld_d;
      flags_q <= flags_d;
      ec_q    <= ec_d;
    end
  end

  assign res_vld = vld_q;
  assign {res_nomatch, res_undef, res_trap, res_ignore, res_exec, res_excl_xs} = flags_q;
  assign res_ec  = ec_q;

  assert_vld_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> res_vld);
  assert_vld_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !res_vld);
  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $onehot({res_nomatch, res_undef, res_trap, res_ignore, res_exec}));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> $stable({res_nomatch, res_undef, res_trap, res_ignore, res_exec, res_excl_xs, res_ec}));
  assert_trap_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (res_trap == (res_ec == TRAP_EC)));
  assert_variant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_excl_xs |-> res_exec);
  assert_nomatch_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_nomatch |-> !(res_undef || res_trap || res_ignore || res_exec));

endmodule

// File: rtl/tlbm_perm_top.sv
module tlbm_perm_top
  import tlbm_pkg::*;
#(
  parameter int OP0_W = 2,
  parameter int OP1_W = 3,
  parameter int CRN_W = 4,
  parameter int CRM_W = 4,
  parameter int OP2_W = 3,
  parameter int EC_W  = 6,
  parameter logic [EC_W-1:0] TRAP_EC = 6'h18,
  parameter bit XS_FORM_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic [OP0_W-1:0] enc_op0,
  input  logic [OP1_W-1:0] enc_op1,
  input  logic [CRN_W-1:0] enc_crn,
  input  logic [CRM_W-1:0] enc_crm,
  input  logic [OP2_W-1:0] enc_op2,
  input  logic [1:0]       cur_el,
  input  logic             feat_os_inval,
  input  logic             feat_a64,
  input  logic             feat_xs,
  input  logic             feat_fgt,
  input  logic             feat_el3,
  input  logic             feat_hcx,
  input  logic             feat_realm,
  input  logic             ctl_el2_en,
  input  logic             ctl_trap_tlb,
  input  logic             ctl_trap_os,
  input  logic             ctl_el3_fgt_en,
  input  logic             ctl_fgt_inst,
  input  logic             ctl_hcx_en,
  input  logic             ctl_hcx_fgt_nxs,
  input  logic             ctl_el1_sec_ok,
  output logic             res_vld,
  output logic             res_nomatch,
  output logic             res_undef,
  output logic             res_trap,
  output logic             res_ignore,
  output logic             res_exec,
  output logic             res_excl_xs,
  output logic [EC_W-1:0]  res_ec
);

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  feat_t    feat;
  ctl_t     ctl;
  logic     hit_base, hit_nxs;
  verdict_e verdict;
  logic     excl_xs;

  assign feat = '{os_inval: feat_os_inval, a64: feat_a64, xs: feat_xs, fgt: feat_fgt,
                  el3: feat_el3, hcx: feat_hcx, realm: feat_realm};
  assign ctl  = '{el2_en: ctl_el2_en, trap_tlb: ctl_trap_tlb, trap_os: ctl_trap_os,
                  el3_fgt_en: ctl_el3_fgt_en, fgt_inst: ctl_fgt_inst, hcx_en: ctl_hcx_en,
                  hcx_fgt_nxs: ctl_hcx_fgt_nxs, el1_sec_ok: ctl_el1_sec_ok};

  tlbm_decode #(
    .OP0_W(OP0_W), .OP1_W(OP1_W), .CRN_W(CRN_W), .CRM_W(CRM_W), .OP2_W(OP2_W),
    .XS_FORM_EN(XS_FORM_EN)
  ) decode_i (
    .op0(enc_op0), .op1(enc_op1), .crn(enc_crn), .crm(enc_crm), .op2(enc_op2),
    .hit_base(hit_base), .hit_nxs(hit_nxs)
  );

  tlbm_perm perm_i (
    .hit_base(hit_base), .hit_nxs(hit_nxs), .el(cur_el), .feat(feat), .ctl(ctl),
    .verdict(verdict), .excl_xs(excl_xs)
  );

  tlbm_resreg #(.EC_W(EC_W), .TRAP_EC(TRAP_EC)) resreg_i (
    .clk(clk), .rst_n(rst_sync_q), .req_vld(req_vld), .verdict(verdict), .excl_xs(excl_xs),
    .res_vld(res_vld), .res_nomatch(res_nomatch), .res_undef(res_undef), .res_trap(res_trap),
    .res_ignore(res_ignore), .res_exec(res_exec), .res_excl_xs(res_excl_xs), .res_ec(res_ec)
  );

  assert_feat_gate_R3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (req_vld && (hit_base || hit_nxs) && !(feat_os_inval && feat_a64)) |=> res_undef);
  assert_el0_undef_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (req_vld && (hit_base || hit_nxs) && cur_el == EL_0) |=> res_undef);
  assert_el2_exec_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (req_vld && cur_el == EL_2 && feat_os_inval && feat_a64 &&
     (hit_base || (hit_nxs && feat_xs))) |=> res_exec);
  assert_coarse_trap_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (req_vld && cur_el == EL_1 && feat_os_inval && feat_a64 && hit_base &&
     ctl_el2_en && (ctl_trap_tlb || ctl_trap_os)) |=> res_trap);
  assert_nomatch_R1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (req_vld && !hit_base && !hit_nxs) |=> res_nomatch);

endmodule

// File: tb/tlbm_perm_top_tb_top.sv
module tlbm_perm_top_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_vld = 1'b0;
  logic [1:0] op0 = '0;
  logic [2:0] op1 = '0;
  logic [3:0] crn = '0;
  logic [3:0] crm = '0;
  logic [2:0] op2 = '0;
  logic [1:0] el = '0;
  logic [6:0] fb = '0;
  logic [7:0] cb = '0;

  logic res_vld, res_nomatch, res_undef, res_trap, res_ignore, res_exec, res_excl_xs;
  logic [5:0] res_ec;

  tlbm_perm_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld),
    .enc_op0(op0), .enc_op1(op1), .enc_crn(crn), .enc_crm(crm), .enc_op2(op2),
    .cur_el(el),
    .feat_os_inval(fb[0]), .feat_a64(fb[1]), .feat_xs(fb[2]), .feat_fgt(fb[3]),
    .feat_el3(fb[4]), .feat_hcx(fb[5]), .feat_realm(fb[6]),
    .ctl_el2_en(cb[0]), .ctl_trap_tlb(cb[1]), .ctl_trap_os(cb[2]), .ctl_el3_fgt_en(cb[3]),
    .ctl_fgt_inst(cb[4]), .ctl_hcx_en(cb[5]), .ctl_hcx_fgt_nxs(cb[6]), .ctl_el1_sec_ok(cb[7]),
    .res_vld(res_vld), .res_nomatch(res_nomatch), .res_undef(res_undef), .res_trap(res_trap),
    .res_ignore(res_ignore), .res_exec(res_exec), .res_excl_xs(res_excl_xs), .res_ec(res_ec)
  );

  typedef struct {
    logic [11:0] val;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  function automatic logic [11:0] observed();
    return {res_nomatch, res_undef, res_trap, res_ignore, res_exec, res_excl_xs, res_ec};
  endfunction

  function automatic item_t predict(logic [1:0] o0, logic [2:0] o1, logic [3:0] cn,
                                    logic [3:0] cm, logic [2:0] o2, logic [1:0] lvl,
                                    logic [6:0] f, logic [7:0] c);
    item_t it;
    logic base, nxs, fg;
    base = (o0 == 2'b01) && (o1 == 3'b000) && (cn == 4'b1000) && (cm == 4'b0001) && (o2 == 3'b010);
    nxs  = (o0 == 2'b01) && (o1 == 3'b000) && (cn == 4'b1001) && (cm == 4'b0001) && (o2 == 3'b010);
    it.val = 12'b0;
    if (!base && !nxs) begin
      it.val[11] = 1'b1; it.tag = "R1";
    end else if (!(f[0] && f[1])) begin
      it.val[10] = 1'b1; it.tag = "R3";
    end else if (nxs && !f[2]) begin
      it.val[10] = 1'b1; it.tag = "R2";
    end else if (lvl == 2'd0) begin
      it.val[10] = 1'b1; it.tag = "R4";
    end else if (lvl == 2'd1) begin
      fg = c[0] && f[3] && (!f[4] || c[3]) && c[4] && (!nxs || (f[5] && (!c[5] || !c[6])));
      if (c[0] && (c[1] || c[2])) begin
        it.val[9] = 1'b1; it.val[5:0] = 6'h18; it.tag = "R5";
      end else if (fg) begin
        it.val[9] = 1'b1; it.val[5:0] = 6'h18; it.tag = nxs ? "R7" : "R6";
      end else begin
        it.val[7] = 1'b1; it.val[6] = nxs;
        it.tag = !c[0] ? "R12" : (nxs ? "R7" : "R6");
      end
    end else if (lvl == 2'd2) begin
      it.val[7] = 1'b1; it.val[6] = nxs; it.tag = "R8";
    end else begin
      if (f[6] && !c[7]) begin
        it.val[8] = 1'b1; it.tag = "R9";
      end else begin
        it.val[7] = 1'b1; it.val[6] = nxs; it.tag = nxs ? "R11" : "R9";
      end
    end
    return it;
  endfunction

  task automatic send(logic [1:0] o0, logic [2:0] o1, logic [3:0] cn, logic [3:0] cm,
                      logic [2:0] o2, logic [1:0] lvl, logic [6:0] f, logic [7:0] c);
    @(negedge clk);
    op0 = o0; op1 = o1; crn = cn; crm = cm; op2 = o2; el = lvl; fb = f; cb = c;
    req_vld = 1'b1;
    sb_q.push_back(predict(o0, o1, cn, cm, o2, lvl, f, c));
  endtask

  task automatic send_form(int form, logic [1:0] lvl, logic [6:0] f, logic [7:0] c);
    if (form == 0)      send(2'b01, 3'b000, 4'b1000, 4'b0001, 3'b010, lvl, f, c);
    else if (form == 1) send(2'b01, 3'b000, 4'b1001, 4'b0001, 3'b010, lvl, f, c);
    else if (form == 2) send(2'b01, 3'b000, 4'b1000, 4'b0001, 3'b011, lvl, f, c);
    else if (form == 3) send(2'b11, 3'b000, 4'b1000, 4'b0001, 3'b010, lvl, f, c);
    else if (form == 4) send(2'b01, 3'b001, 4'b1001, 4'b0001, 3'b010, lvl, f, c);
    else                send(2'b01, 3'b000, 4'b1000, 4'b0010, 3'b010, lvl, f, c);
  endtask

  task automatic idle();
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_vld) begin
      item_t exp_it;
      n_checks++;
      if (sb_q.size() == 0) begin
        n_errors++;
        $display("FAIL R10: result without request, got %h expected none", observed());
      end else begin
        exp_it = sb_q.pop_front();
        if (observed() !== exp_it.val) begin
          n_errors++;
          $display("FAIL %s: got %h expected %h", exp_it.tag, observed(), exp_it.val);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  localparam logic [6:0] F_ALL = 7'h7f;
  localparam logic [6:0] F_MIN = 7'b0000111;

  initial begin
    logic [15:0] lfsr;
    logic [11:0] held;
    repeat (3) @(negedge clk);
    n_checks++;
    if (res_vld !== 1'b0 || observed() !== 12'h0) begin
      n_errors++;
      $display("FAIL R10: reset state got %b/%h expected 0/000", res_vld, observed());
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Directed priority edges
    send_form(0, 2'd1, F_MIN, 8'h00);           // R12 execute, base
    send_form(1, 2'd1, F_MIN, 8'h00);           // R12 execute, variant R11
    send_form(1, 2'd2, 7'b0000011, 8'hff);      // R2 no xs feature at EL2
    send_form(0, 2'd2, 7'b1111110, 8'h00);      // R3 missing os_inval
    send_form(0, 2'd3, 7'b1111101, 8'h80);      // R3 missing a64
    send_form(0, 2'd0, F_ALL, 8'h00);           // R4
    send_form(0, 2'd1, F_ALL, 8'b00000011);     // R5 via trap_tlb
    send_form(1, 2'd1, F_ALL, 8'b00000101);     // R5 via trap_os
    send_form(0, 2'd1, 7'b0001111, 8'b00010001);// R6 no el3
    send_form(0, 2'd1, F_ALL, 8'b00010001);     // R6 el3 present, enable low -> exec
    send_form(1, 2'd1, 7'b0001111, 8'b00011001);// R7 no hcx -> exec
    send_form(1, 2'd1, F_ALL, 8'b01111001);     // R7 hcx_en and nxs bit -> exec
    send_form(1, 2'd1, F_ALL, 8'b00011001);     // R7 trap
    send_form(0, 2'd2, F_ALL, 8'h7f);           // R8
    send_form(0, 2'd3, F_ALL, 8'h00);           // R9 ignore
    send_form(1, 2'd3, F_ALL, 8'h80);           // R9 execute
    send_form(2, 2'd2, F_ALL, 8'h00);           // R1 op2 mismatch
    send_form(3, 2'd2, F_ALL, 8'h00);           // R1 op0 mismatch
    send_form(0, 2'd1, F_ALL, 8'b00000011);     // trap, then hold check
    idle();

    // R10 hold: change inputs with no strobe, outputs must stay
    el = 2'd2; fb = F_ALL; cb = 8'h00;
    @(negedge clk);
    held = observed();
    @(negedge clk);
    n_checks++;
    if (res_vld !== 1'b0 || observed() !== held || held !== {3'b001, 3'b000, 6'h18}) begin
      n_errors++;
      $display("FAIL R10: hold got %b/%h expected 0/%h", res_vld, observed(),
               {3'b001, 3'b000, 6'h18});
    end

    // Pseudo-random sweep over levels, forms and all flag bits
    lfsr = 16'hace1;
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send_form(i % 6, lfsr[1:0], lfsr[8:2] | ((i % 3 == 0) ? 7'b0000011 : 7'b0),
                {lfsr[15:9], lfsr[0] ^ lfsr[5]});
      if (i % 7 == 6) idle();
    end
    idle();
    repeat (4) @(negedge clk);
    n_checks++;
    if (sb_q.size() != 0) begin
      n_errors++;
      $display("FAIL R10: pending results got %0d expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule